// File: doc/BRIEF.md
# Chunked Block-Copy Engine

This block is the sequencer at the heart of a memory-to-memory copy channel. When a control block pulses `start_i`, the engine takes a staged descriptor: source address, destination address, byte count, read and write size exponents and a repeat flag. It copies that descriptor into its working (exec) registers and then moves the bytes as a series of bursts. Each burst is a read of up to 64 bytes into an internal buffer, followed by a write of the same bytes. The working registers track progress after every burst. When the copy finishes, the engine raises a done or an error status and gives a one-cycle end pulse back to the control block.

The burst size is 2 to the power of the size exponent, capped at 64 bytes. The copy is made of as many full bursts as fit in the byte count, then one shorter tail burst for what is left. All three memory channels use valid/ready handshakes:

- The read command, read data and write command are each accepted on a cycle where valid and ready are both high.
- The engine holds a command's valid, address, length and data steady until the handshake completes.
- The engine asserts `rd_dat_ready_o` only while it is waiting for the data of an accepted read command.
- The memory side may stall any channel for as long as it needs.

Only one burst is in flight at any time.

Top module: `dma_chunk_engine`

## Requirements
- R1: After reset, all of the following are 0: `busy_o`, `done_o`, `err_o`, `end_o`, all memory valids, and all exec registers.
- R2: A start in idle with a staged byte count of 0 sets `done_o`=1 and `err_o`=0 and pulses `end_o` on the next cycle. It issues no memory request and leaves the exec registers unchanged. This check runs before the size check of R3.
- R3: A start in idle with a nonzero count and differing read and write size exponents sets `err_o`=1 and `done_o`=0 and pulses `end_o` on the next cycle. It moves no data and leaves the exec registers unchanged.
- R4: Any other start in idle loads the exec byte count, source, destination, size exponent and repeat flag from the staged values, sets `busy_o`, and clears `done_o` and `err_o`. Both status bits stay 0 while `busy_o` is high.
- R5: The chunk is 2^min(E,6) bytes, where E is the 4-bit size exponent. Each burst length is the smaller of the chunk and the remaining exec byte count, so a nonzero remainder gives one final shorter burst. Every burst length lies in 1..64.
- R6: Each burst issues a read command at the exec source, accepts one read-data beat, then issues a write command at the exec destination with the same length. Byte lane i of the data bus is bits [8i+7:8i]. Lanes below the length carry the read bytes; lanes at or above the length are 0.
- R7: After each accepted write that is not the last, the exec source and destination rise by the burst length and the exec byte count falls by it.
- R8: After the last write, the exec registers hold one of two sets of values. With repeat set, they are reloaded with the byte count, source and destination captured at start. Otherwise they hold count 0 and the final addresses.
- R9: On the cycle after the last write is accepted, `busy_o` falls, `done_o` rises, and `end_o` is high for exactly that one cycle.
- R10: A start pulse while `busy_o` is high is ignored: the exec registers and the burst sequence are unaffected.
- R11: A command whose valid is high and whose ready is low keeps valid, address and length (and write data) unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse from the control block |
| nxt_repeat_i | input | 1 | Staged repeat flag |
| nxt_rd_lg_i | input | 4 | Staged read size exponent |
| nxt_wr_lg_i | input | 4 | Staged write size exponent |
| nxt_bytes_i | input | CNT_W | Staged byte count |
| nxt_src_i | input | ADDR_W | Staged source address |
| nxt_dst_i | input | ADDR_W | Staged destination address |
| busy_o | output | 1 | Transfer in progress (the run state) |
| done_o | output | 1 | Completion status |
| err_o | output | 1 | Size-mismatch status |
| end_o | output | 1 | One-cycle pulse when a start has been resolved |
| exec_bytes_o | output | CNT_W | Remaining byte count |
| exec_src_o | output | ADDR_W | Current source address |
| exec_dst_o | output | ADDR_W | Current destination address |
| exec_lg_o | output | 4 | Size exponent in use |
| exec_repeat_o | output | 1 | Repeat flag in use |
| rd_cmd_valid_o | output | 1 | Read command valid |
| rd_cmd_ready_i | input | 1 | Read command ready |
| rd_cmd_addr_o | output | ADDR_W | Read address |
| rd_cmd_len_o | output | MAX_LG+1 | Read length in bytes |
| rd_dat_valid_i | input | 1 | Read data valid |
| rd_dat_ready_o | output | 1 | Read data ready |
| rd_dat_i | input | 8*2^MAX_LG | Read data, lane i at bits [8i+7:8i] |
| wr_valid_o | output | 1 | Write command valid |
| wr_ready_i | input | 1 | Write command ready |
| wr_addr_o | output | ADDR_W | Write address |
| wr_len_o | output | MAX_LG+1 | Write length in bytes |
| wr_data_o | output | 8*2^MAX_LG | Write data, lanes at or above the length are 0 |

## Verification
The assertions check the following on every cycle:

- Commands stay stable under back-pressure.
- Burst lengths stay in range.
- The exec byte count falls by exactly the accepted write length.
- Status stays clear while busy, and `end_o` never coincides with busy.
- Zero-length and size-mismatch starts resolve in one cycle.
- A start during a transfer leaves the exec count and source untouched.

The bench scenarios cover the rest: the sequence of burst addresses and lengths for a given count and exponent (including the clamp above 6 and the remainder tail), the lane contents of the write data, and the reload or final values after the last burst.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_REQ = 2'd1,
    ST_RD_DAT = 2'd2,
    ST_WR_REQ = 2'd3
  } eng_state_e;
endpackage

// File: rtl/dma_chunk_sizer.sv
module dma_chunk_sizer #(
  parameter int CNT_W  = 32,
  parameter int MAX_LG = 6,
  localparam int LEN_W = MAX_LG + 1
) (
  input  logic [3:0]       size_lg,
  input  logic [CNT_W-1:0] remain,
  output logic [LEN_W-1:0] burst_len
);
  localparam logic [3:0] CAP = 4'(MAX_LG);

  logic [3:0]       eff_lg;
  logic [LEN_W-1:0] chunk;

  always_comb begin
    eff_lg = (size_lg > CAP) ? CAP : size_lg;
    chunk  = LEN_W'(1) << eff_lg;
    if (remain < CNT_W'(chunk))
      burst_len = remain[LEN_W-1:0];
    else
      burst_len = chunk;
  end
endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
  parameter int MAX_LG = 6,
  localparam int LANES = 1 << MAX_LG,
  localparam int LEN_W = MAX_LG + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LEN_W-1:0]   len,
  input  logic [8*LANES-1:0] din,
  output logic [8*LANES-1:0] dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (load)
        q <= (i < int'(len)) ? din[8*i +: 8] : 8'h00;
    end
    assign dout[8*i +: 8] = q;
  end
endmodule

// File: rtl/dma_exec_track.sv
module dma_exec_track #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              reload,
  input  logic [LEN_W-1:0]  step_len,
  input  logic [CNT_W-1:0]  ld_bytes,
  input  logic [ADDR_W-1:0] ld_src,
  input  logic [ADDR_W-1:0] ld_dst,
  output logic [CNT_W-1:0]  cur_bytes,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst
);
  logic [CNT_W-1:0]  base_bytes;
  logic [ADDR_W-1:0] base_src, base_dst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_bytes  <= '0;
      cur_src    <= '0;
      cur_dst    <= '0;
      base_bytes <= '0;
      base_src   <= '0;
      base_dst   <= '0;
    end else if (load) begin
      cur_bytes  <= ld_bytes;
      cur_src    <= ld_src;
      cur_dst    <= ld_dst;
      base_bytes <= ld_bytes;
      base_src   <= ld_src;
      base_dst   <= ld_dst;
    end else if (reload) begin
      cur_bytes <= base_bytes;
      cur_src   <= base_src;
      cur_dst   <= base_dst;
    end else if (step) begin
      cur_bytes <= cur_bytes - CNT_W'(step_len);
      cur_src   <= cur_src + ADDR_W'(step_len);
      cur_dst   <= cur_dst + ADDR_W'(step_len);
    end
  end
endmodule

// File: rtl/dma_chunk_engine.sv
module dma_chunk_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int MAX_LG = 6,
  localparam int LEN_W    = MAX_LG + 1,
  localparam int BUF_BITS = 8 * (1 << MAX_LG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                nxt_repeat_i,
  input  logic [3:0]          nxt_rd_lg_i,
  input  logic [3:0]          nxt_wr_lg_i,
  input  logic [CNT_W-1:0]    nxt_bytes_i,
  input  logic [ADDR_W-1:0]   nxt_src_i,
  input  logic [ADDR_W-1:0]   nxt_dst_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic                end_o,
  output logic [CNT_W-1:0]    exec_bytes_o,
  output logic [ADDR_W-1:0]   exec_src_o,
  output logic [ADDR_W-1:0]   exec_dst_o,
  output logic [3:0]          exec_lg_o,
  output logic                exec_repeat_o,
  output logic                rd_cmd_valid_o,
  input  logic                rd_cmd_ready_i,
  output logic [ADDR_W-1:0]   rd_cmd_addr_o,
  output logic [LEN_W-1:0]    rd_cmd_len_o,
  input  logic                rd_dat_valid_i,
  output logic                rd_dat_ready_o,
  input  logic [BUF_BITS-1:0] rd_dat_i,
  output logic                wr_valid_o,
  input  logic                wr_ready_i,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [LEN_W-1:0]    wr_len_o,
  output logic [BUF_BITS-1:0] wr_data_o
);
  eng_state_e       state_q, state_d;
  logic [LEN_W-1:0] cur_len_q;
  logic [LEN_W-1:0] next_len;
  logic             take_start, size_bad, count_zero, launch;
  logic             rd_fire, dat_fire, wr_fire, last_fire;
  logic             trk_step, trk_reload;

  // start decode (R2, R3, R4, R10)
  assign take_start = start_i && (state_q == ST_IDLE);
  assign count_zero = (nxt_bytes_i == '0);
  assign size_bad   = (nxt_rd_lg_i != nxt_wr_lg_i);
  assign launch     = take_start && !count_zero && !size_bad;

  // handshakes
  assign rd_cmd_valid_o = (state_q == ST_RD_REQ);
  assign rd_dat_ready_o = (state_q == ST_RD_DAT);
  assign wr_valid_o     = (state_q == ST_WR_REQ);
  assign rd_fire   = rd_cmd_valid_o && rd_cmd_ready_i;
  assign dat_fire  = rd_dat_ready_o && rd_dat_valid_i;
  assign wr_fire   = wr_valid_o && wr_ready_i;
  assign last_fire = wr_fire && (exec_bytes_o == CNT_W'(cur_len_q));

  assign trk_reload = last_fire && exec_repeat_o;
  assign trk_step   = wr_fire && !trk_reload;

  dma_chunk_sizer #(.CNT_W(CNT_W), .MAX_LG(MAX_LG)) u_sizer (
    .size_lg  (exec_lg_o),
    .remain   (exec_bytes_o),
    .burst_len(next_len)
  );

  dma_exec_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .step     (trk_step),
    .reload   (trk_reload),
    .step_len (cur_len_q),
    .ld_bytes (nxt_bytes_i),
    .ld_src   (nxt_src_i),
    .ld_dst   (nxt_dst_i),
    .cur_bytes(exec_bytes_o),
    .cur_src  (exec_src_o),
    .cur_dst  (exec_dst_o)
  );

  dma_burst_buf #(.MAX_LG(MAX_LG)) u_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .load (dat_fire),
    .len  (cur_len_q),
    .din  (rd_dat_i),
    .dout (wr_data_o)
  );

  assign rd_cmd_addr_o = exec_src_o;
  assign rd_cmd_len_o  = next_len;
  assign wr_addr_o     = exec_dst_o;
  assign wr_len_o      = cur_len_q;
  assign busy_o        = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (launch)    state_d = ST_RD_REQ;
      ST_RD_REQ: if (rd_fire)   state_d = ST_RD_DAT;
      ST_RD_DAT: if (dat_fire)  state_d = ST_WR_REQ;
      ST_WR_REQ: if (last_fire) state_d = ST_IDLE;
                 else if (wr_fire) state_d = ST_RD_REQ;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      cur_len_q     <= '0;
      exec_lg_o     <= '0;
      exec_repeat_o <= 1'b0;
      done_o        <= 1'b0;
      err_o         <= 1'b0;
      end_o         <= 1'b0;
    end else begin
      state_q <= state_d;
      end_o   <= 1'b0;
      if (rd_fire) cur_len_q <= next_len;
      if (launch) begin
        exec_lg_o     <= nxt_rd_lg_i;
        exec_repeat_o <= nxt_repeat_i;
      end
      if (take_start) begin
        if (count_zero) begin
          done_o <= 1'b1;
          err_o  <= 1'b0;
          end_o  <= 1'b1;
        end else if (size_bad) begin
          done_o <= 1'b0;
          err_o  <= 1'b1;
          end_o  <= 1'b1;
        end else begin
          done_o <= 1'b0;
          err_o  <= 1'b0;
        end
      end
      if (last_fire) begin
        done_o <= 1'b1;
        end_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chunk_engine_chk.sv
module dma_chunk_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int MAX_LG = 6,
  localparam int LEN_W = MAX_LG + 1,
  localparam int MAXB  = 1 << MAX_LG
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [3:0]        nxt_rd_lg_i,
  input logic [3:0]        nxt_wr_lg_i,
  input logic [CNT_W-1:0]  nxt_bytes_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              end_o,
  input logic [CNT_W-1:0]  exec_bytes_o,
  input logic [ADDR_W-1:0] exec_src_o,
  input logic              rd_cmd_valid_o,
  input logic              rd_cmd_ready_i,
  input logic [ADDR_W-1:0] rd_cmd_addr_o,
  input logic [LEN_W-1:0]  rd_cmd_len_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [LEN_W-1:0]  wr_len_o
);
  assert_zero_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && (nxt_bytes_i == '0) |=> done_o && !err_o && end_o && !busy_o);

  assert_size_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && (nxt_bytes_i != '0) && (nxt_rd_lg_i != nxt_wr_lg_i)
    |=> err_o && !done_o && end_o && !busy_o);

  assert_status_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o && !err_o);

  assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd_valid_o |-> (rd_cmd_len_o != '0) && (int'(rd_cmd_len_o) <= MAXB)) and
    (wr_valid_o |-> (wr_len_o != '0) && (int'(wr_len_o) <= MAXB)));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_ready_i && (exec_bytes_o != CNT_W'(wr_len_o))
    |=> exec_bytes_o == $past(exec_bytes_o) - CNT_W'($past(wr_len_o)));

  assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> !busy_o);

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !(wr_valid_o && wr_ready_i)
    |=> $stable(exec_bytes_o) && $stable(exec_src_o));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid_o && !rd_cmd_ready_i
    |=> rd_cmd_valid_o && $stable(rd_cmd_addr_o) && $stable(rd_cmd_len_o));

  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i
    |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_len_o));
endmodule

bind dma_chunk_engine dma_chunk_engine_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_LG(MAX_LG)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .nxt_rd_lg_i   (nxt_rd_lg_i),
  .nxt_wr_lg_i   (nxt_wr_lg_i),
  .nxt_bytes_i   (nxt_bytes_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .end_o         (end_o),
  .exec_bytes_o  (exec_bytes_o),
  .exec_src_o    (exec_src_o),
  .rd_cmd_valid_o(rd_cmd_valid_o),
  .rd_cmd_ready_i(rd_cmd_ready_i),
  .rd_cmd_addr_o (rd_cmd_addr_o),
  .rd_cmd_len_o  (rd_cmd_len_o),
  .wr_valid_o    (wr_valid_o),
  .wr_ready_i    (wr_ready_i),
  .wr_addr_o     (wr_addr_o),
  .wr_len_o      (wr_len_o)
);

// File: tb/dma_chunk_engine_test.sv
module dma_chunk_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 32;
  localparam int LG = 6;
  localparam int LW = LG + 1;
  localparam int BB = 8 * (1 << LG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, nxt_repeat_i = 1'b0;
  logic [3:0] nxt_rd_lg_i = '0, nxt_wr_lg_i = '0;
  logic [CW-1:0] nxt_bytes_i = '0;
  logic [AW-1:0] nxt_src_i = '0, nxt_dst_i = '0;
  logic busy_o, done_o, err_o, end_o, exec_repeat_o;
  logic [CW-1:0] exec_bytes_o;
  logic [AW-1:0] exec_src_o, exec_dst_o;
  logic [3:0] exec_lg_o;
  logic rd_cmd_valid_o, rd_cmd_ready_i = 1'b0;
  logic [AW-1:0] rd_cmd_addr_o;
  logic [LW-1:0] rd_cmd_len_o;
  logic rd_dat_valid_i = 1'b0, rd_dat_ready_o;
  logic [BB-1:0] rd_dat_i = '0;
  logic wr_valid_o, wr_ready_i = 1'b0;
  logic [AW-1:0] wr_addr_o;
  logic [LW-1:0] wr_len_o;
  logic [BB-1:0] wr_data_o;

  int checks = 0;
  int fails = 0;
  logic [CW-1:0] ex_bytes = '0;
  logic [AW-1:0] ex_src = '0, ex_dst = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chunk_engine #(.ADDR_W(AW), .CNT_W(CW), .MAX_LG(LG)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA7;
  endfunction

  function automatic logic [BB-1:0] mem_beat(input logic [AW-1:0] src);
    logic [BB-1:0] v;
    for (int i = 0; i < BB/8; i++) v[8*i +: 8] = pat(src + AW'(i));
    return v;
  endfunction

  function automatic logic [BB-1:0] exp_wr(input logic [AW-1:0] src, input int len);
    logic [BB-1:0] v;
    for (int i = 0; i < BB/8; i++) v[8*i +: 8] = (i < len) ? pat(src + AW'(i)) : 8'h00;
    return v;
  endfunction

  function automatic int blen(input logic [CW-1:0] rem, input logic [3:0] lg);
    int c;
    c = 1 << ((lg > 4'd6) ? 6 : int'(lg));
    return (rem < CW'(c)) ? int'(rem) : c;
  endfunction

  task automatic run_xfer(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                          input logic [CW-1:0] bytes, input logic [3:0] rlg,
                          input logic [3:0] wlg, input bit rep, input bit poke);
    logic [CW-1:0] rem;
    logic [AW-1:0] s, d;
    int len;
    bit poked;
    poked = 1'b0;
    @(negedge clk);
    nxt_src_i = src; nxt_dst_i = dst; nxt_bytes_i = bytes;
    nxt_rd_lg_i = rlg; nxt_wr_lg_i = wlg; nxt_repeat_i = rep;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (bytes == '0) begin
      chk(done_o && !err_o && end_o && !busy_o, "R2 zero-length status",
          {done_o, err_o, end_o, busy_o}, 4'b1010);
      chk(exec_bytes_o == ex_bytes && exec_src_o == ex_src && exec_dst_o == ex_dst,
          "R2 exec untouched", exec_src_o, ex_src);
      chk(!rd_cmd_valid_o && !wr_valid_o, "R2 no request", rd_cmd_valid_o, 0);
      return;
    end
    if (rlg != wlg) begin
      chk(err_o && !done_o && end_o && !busy_o, "R3 mismatch status",
          {done_o, err_o, end_o, busy_o}, 4'b0110);
      chk(exec_bytes_o == ex_bytes && exec_src_o == ex_src && exec_dst_o == ex_dst,
          "R3 exec untouched", exec_bytes_o, ex_bytes);
      chk(!rd_cmd_valid_o && !wr_valid_o, "R3 no request", rd_cmd_valid_o, 0);
      return;
    end
    chk(busy_o && !done_o && !err_o && exec_bytes_o == bytes && exec_src_o == src &&
        exec_dst_o == dst && exec_lg_o == rlg && exec_repeat_o == rep,
        "R4 load on start", exec_src_o, src);
    rem = bytes; s = src; d = dst;
    while (rem != '0) begin
      len = blen(rem, rlg);
      for (int k = 0; k < 50 && !rd_cmd_valid_o; k++) @(negedge clk);
      repeat ($urandom % 3) @(negedge clk);
      chk(rd_cmd_valid_o && rd_cmd_addr_o == s && int'(rd_cmd_len_o) == len,
          "R5 read command", {rd_cmd_addr_o, 25'd0, rd_cmd_len_o}, {s, 25'd0, LW'(len)});
      rd_cmd_ready_i = 1'b1;
      @(negedge clk);
      rd_cmd_ready_i = 1'b0;
      if (poke && !poked) begin
        poked = 1'b1;
        nxt_src_i = ~src; nxt_bytes_i = 32'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(exec_src_o == s && exec_bytes_o == rem, "R10 start while busy ignored",
            exec_src_o, s);
      end
      chk(rd_dat_ready_o && !wr_valid_o, "R6 waiting for data", rd_dat_ready_o, 1);
      repeat ($urandom % 3) @(negedge clk);
      rd_dat_valid_i = 1'b1; rd_dat_i = mem_beat(s);
      @(negedge clk);
      rd_dat_valid_i = 1'b0; rd_dat_i = '0;
      for (int k = 0; k < 50 && !wr_valid_o; k++) @(negedge clk);
      repeat ($urandom % 3) @(negedge clk);
      chk(wr_valid_o && wr_addr_o == d && int'(wr_len_o) == len,
          "R6 write command", {wr_addr_o, 25'd0, wr_len_o}, {d, 25'd0, LW'(len)});
      chk(wr_data_o == exp_wr(s, len), "R6 write data lanes",
          wr_data_o[63:0], exp_wr(s, len) >> 0);
      wr_ready_i = 1'b1;
      @(negedge clk);
      wr_ready_i = 1'b0;
      rem = rem - CW'(len); s = s + AW'(len); d = d + AW'(len);
      if (rem != '0)
        chk(busy_o && exec_bytes_o == rem && exec_src_o == s && exec_dst_o == d,
            "R7 exec advance", exec_bytes_o, rem);
    end
    chk(!busy_o && done_o && !err_o && end_o, "R9 completion",
        {busy_o, done_o, err_o, end_o}, 4'b0101);
    if (rep) begin
      chk(exec_bytes_o == bytes && exec_src_o == src && exec_dst_o == dst,
          "R8 repeat reload", exec_src_o, src);
      ex_bytes = bytes; ex_src = src; ex_dst = dst;
    end else begin
      chk(exec_bytes_o == '0 && exec_src_o == s && exec_dst_o == d,
          "R8 final values", exec_dst_o, d);
      ex_bytes = '0; ex_src = s; ex_dst = d;
    end
    @(negedge clk);
    chk(!end_o && done_o, "R9 end single pulse", end_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] lg;
    logic [CW-1:0] n;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !end_o && !rd_cmd_valid_o && !wr_valid_o &&
        exec_bytes_o == '0 && exec_src_o == '0 && exec_dst_o == '0,
        "R1 reset state", {busy_o, done_o, err_o}, 0);
    run_xfer(32'h100, 32'h800, 32'd0, 4'd3, 4'd3, 1'b0, 1'b0);  // R2
    run_xfer(32'h100, 32'h800, 32'd40, 4'd3, 4'd5, 1'b0, 1'b0); // R3
    run_xfer(32'h100, 32'h800, 32'd0, 4'd2, 4'd5, 1'b0, 1'b0);  // R2 wins over R3
    run_xfer(32'h200, 32'h900, 32'd64, 4'd6, 4'd6, 1'b0, 1'b0); // R5 exact chunk
    run_xfer(32'h203, 32'h911, 32'd65, 4'd6, 4'd6, 1'b0, 1'b0); // R5 one-byte tail
    run_xfer(32'h300, 32'hA00, 32'd150, 4'd11, 4'd11, 1'b0, 1'b0); // R5 clamp
    run_xfer(32'h010, 32'h020, 32'd5, 4'd0, 4'd0, 1'b0, 1'b0);  // R5 byte chunks
    run_xfer(32'h400, 32'hB00, 32'd37, 4'd4, 4'd4, 1'b1, 1'b1); // R8 repeat, R10
    run_xfer(32'h500, 32'hC00, 32'd0, 4'd1, 4'd1, 1'b0, 1'b0);  // R2 after repeat
    for (int t = 0; t < 30; t++) begin
      lg = 4'($urandom % 10);
      n = CW'($urandom % ((lg < 4'd3) ? 40 : 300));
      run_xfer($urandom, $urandom, n, lg,
               (($urandom % 6) == 0) ? lg + 4'd1 : lg,
               1'($urandom), (($urandom % 4) == 0));
    end
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule